// File: doc/BRIEF.md
# Buffered PWM Generator With Freeze

The block generates one pulse width modulated output from a 16-bit counter. The counter advances on ticks from a prescaler whose ratio is picked by a 3-bit code. Software writes a period value and a pulse width value through a small write port. The writes land in holding registers, and the counter takes them over only when it wraps. The current period therefore always finishes with the settings it started with.

Each wrap starts a new period and sets a status flag. The flag tells software that the holding registers are free for the settings of the following period. The flag raises an interrupt request tagged with a 3-bit level. Level zero keeps the request quiet, but the flag still sets. A freeze input halts both the prescaler and the counter so that a debugger can stop the waveform. When freeze drops, the waveform resumes exactly where it stopped.

Register map (`wr_addr_i`): 0 holds the period value P, 1 holds the pulse width W, and 2 is the control word. In the control word, bits 2:0 are the prescaler code, bits 6:4 the interrupt level, and bit 8 the flag clear. Address 3 is ignored.

Top module: `pwm_gen`

## Requirements
- R1: While `rst_ni` is low, `pwm_o`, `flag_o` and `irq_o` are 0 and `irq_level_o` is 0. The counter, the active registers, the holding registers, the prescaler code and the level are all cleared by the asynchronous reset.
- R2: Prescaler code 0..7 (control bits 2:0) divides the clock by 2, 4, 8, 16, 32, 64, 128 and 512 respectively. One counter tick lasts that many clock cycles.
- R3: A period lasts P+1 ticks, where P is the value at address 0 and P=0 gives one tick. The output is high for the first W ticks of each period, where W is the value at address 1. W=1 gives the minimum pulse of one tick.
- R4: W=0 keeps `pwm_o` low in every cycle. W>P keeps `pwm_o` high in every cycle.
- R5: Writes to P and W change nothing in the running period. They take effect from the next period start.
- R6: `flag_o` goes to 1 in the cycle after every period start and stays set until cleared.
- R7: A control write with bit 8 set clears `flag_o`. If a period start falls in the same cycle, the flag stays 1.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and the level (control bits 6:4) is nonzero. `irq_level_o` then shows the level; otherwise it shows 0.
- R9: While `freeze_i` is 1, the prescaler and the counter hold their values and `pwm_o` is unchanged. After release, the waveform continues from the same point, so the period that contains the freeze is longer by the frozen cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Debug freeze, halts prescaler and counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 period, 1 width, 2 control) |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM output |
| flag_o | output | 1 | Period-start flag |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Level of the active request, 0 when idle |

## Verification
A software flag clear and a period start can fall in the same clock cycle; this is the case the set-over-clear priority exists for. The bench first clears the flag just after a rising output edge. It then counts one full period length, computed from P and the prescaler ratio, and times a second clear so that it is sampled on the very edge of the next period start. The flag must read 1 afterwards; a 0 shows the clear won.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned IL_W   = 3;
  localparam int unsigned PRE_W  = 9;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_WIDTH  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  localparam int unsigned CTL_SEL_LSB = 0;
  localparam int unsigned CTL_IL_LSB  = 4;
  localparam int unsigned CTL_CLR_BIT = 8;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 9,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // top code jumps to the full prescaler width, the rest double per step
  always_comb begin
    mask = '0;
    if (&sel_i) begin
      mask = '1;
    end else begin
      for (int i = 0; i < int'(PRE_W); i++) begin
        mask[i] = (i <= int'(sel_i));
      end
    end
  end

  assign tick_o = !freeze_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (!freeze_i) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_PRE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(pre_q)); // R9
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned IL_W   = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              start_i,
  output logic [CNT_W-1:0]  per_sh_o,
  output logic [CNT_W-1:0]  pw_sh_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [IL_W-1:0]   irq_level_o
);
  logic [CNT_W-1:0] per_sh_q, pw_sh_q;
  logic [SEL_W-1:0] sel_q;
  logic [IL_W-1:0]  il_q;
  logic             flag_q;
  logic             wr_per, wr_pw, wr_ctl, clr_req;

  assign wr_per  = wr_en_i && (wr_addr_i == ADDR_PERIOD);
  assign wr_pw   = wr_en_i && (wr_addr_i == ADDR_WIDTH);
  assign wr_ctl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_req = wr_ctl && wr_data_i[CTL_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh_q <= '0;
      pw_sh_q  <= '0;
      sel_q    <= '0;
      il_q     <= '0;
    end else begin
      if (wr_per) per_sh_q <= wr_data_i;
      if (wr_pw)  pw_sh_q  <= wr_data_i;
      if (wr_ctl) begin
        sel_q <= wr_data_i[CTL_SEL_LSB +: SEL_W];
        il_q  <= wr_data_i[CTL_IL_LSB +: IL_W];
      end
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (start_i) begin
      flag_q <= 1'b1;
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end

  assign per_sh_o    = per_sh_q;
  assign pw_sh_o     = pw_sh_q;
  assign sel_o       = sel_q;
  assign flag_o      = flag_q;
  assign irq_o       = flag_q && (il_q != '0);
  assign irq_level_o = irq_o ? il_q : '0;

  AST_FLAG_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> flag_o); // R6
  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !start_i) |=> !flag_o); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R8
  AST_LEVEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_level_o == '0)); // R8
  AST_SHADOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_per |=> (per_sh_o == $past(wr_data_i))); // R5
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_sh_i,
  input  logic [CNT_W-1:0] pw_sh_i,
  output logic             start_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_a_q, pw_a_q;

  assign start_o = tick_i && (cnt_q == per_a_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_a_q <= '0;
      pw_a_q  <= '0;
    end else if (tick_i) begin
      if (start_o) begin
        cnt_q   <= '0;
        per_a_q <= per_sh_i;
        pw_a_q  <= pw_sh_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm_o = (cnt_q < pw_a_q);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_a_q); // R3
  AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> ($stable(per_a_q) && $stable(pw_a_q))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9
  AST_ZERO_WIDTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_a_q == '0) |-> !pwm_o); // R4
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W_P  = CNT_W,
  parameter int unsigned SEL_W_P  = SEL_W,
  parameter int unsigned IL_W_P   = IL_W,
  parameter int unsigned PRE_W_P  = PRE_W,
  parameter int unsigned ADDR_W_P = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                freeze_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W_P-1:0] wr_addr_i,
  input  logic [CNT_W_P-1:0]  wr_data_i,
  output logic                pwm_o,
  output logic                flag_o,
  output logic                irq_o,
  output logic [IL_W_P-1:0]   irq_level_o
);
  logic [CNT_W_P-1:0] per_sh, pw_sh;
  logic [SEL_W_P-1:0] sel;
  logic               tick, start;

  pwm_regs #(
    .CNT_W (CNT_W_P),
    .SEL_W (SEL_W_P),
    .IL_W  (IL_W_P),
    .ADDR_W(ADDR_W_P)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .start_i    (start),
    .per_sh_o   (per_sh),
    .pw_sh_o    (pw_sh),
    .sel_o      (sel),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .irq_level_o(irq_level_o)
  );

  pwm_prescaler #(
    .PRE_W(PRE_W_P),
    .SEL_W(SEL_W_P)
  ) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .freeze_i(freeze_i),
    .sel_i   (sel),
    .tick_o  (tick)
  );

  pwm_core #(
    .CNT_W(CNT_W_P)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .per_sh_i(per_sh),
    .pw_sh_i (pw_sh),
    .start_o (start),
    .pwm_o   (pwm_o)
  );

  AST_FREEZE_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(pwm_o)); // R9
endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freeze = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm, flag, irq;
  logic [2:0]  irq_level;

  always #2.5 clk = ~clk;

  pwm_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(freeze),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_o(pwm), .flag_o(flag), .irq_o(irq), .irq_level_o(irq_level)
  );

  typedef struct { int per; int hi; string req; } item_t;
  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  event mon_rise;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int per, input int hi, input string req);
    item_t it;
    it.per = per; it.hi = hi; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ctl(input int sel, input int il, input bit clr);
    logic [15:0] d;
    d = '0;
    d[2:0] = 3'(sel);
    d[6:4] = 3'(il);
    d[8] = clr;
    wr(2'd2, d);
  endtask

  task automatic wait_empty();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: measures clocks between rising edges and high clocks inside
  int per_cnt = 0;
  int hi_cnt = 0;
  logic pwm_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pwm && !pwm_prev) begin
        if (q.size() != 0) begin
          item_t it;
          it = q.pop_front();
          chk({it.req, " period clocks"}, per_cnt, it.per);
          chk({it.req, " high clocks"}, hi_cnt, it.hi);
        end
        per_cnt = 1;
        hi_cnt = 1;
        -> mon_rise;
      end else begin
        per_cnt++;
        if (pwm) hi_cnt++;
      end
      pwm_prev = pwm;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ok;
    repeat (4) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm), 0);
    chk("R1 flag in reset", int'(flag), 0);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 level in reset", int'(irq_level), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // div 2, P=9, W=3
    wr_ctl(0, 3, 1'b1);
    wr(2'd0, 16'd9);
    wr(2'd1, 16'd3);
    @(mon_rise); @(mon_rise);
    push(20, 6, "R3 div2 P9 W3");
    push(20, 6, "R3 div2 P9 W3");
    wait_empty();
    @(negedge clk);
    chk("R6 flag set after start", int'(flag), 1);
    chk("R8 irq with level 3", int'(irq), 1);
    chk("R8 level 3", int'(irq_level), 3);

    // clear, then clear on a period start edge (period = 20 clocks)
    @(mon_rise);
    wr_ctl(0, 3, 1'b1);
    chk("R7 flag cleared", int'(flag), 0);
    chk("R8 irq off with flag clear", int'(irq), 0);
    repeat (18) @(negedge clk);
    wr_ctl(0, 3, 1'b1);
    chk("R7 set wins over clear", int'(flag), 1);

    // level zero
    @(mon_rise);
    wr_ctl(0, 0, 1'b0);
    chk("R6 flag with level 0", int'(flag), 1);
    chk("R8 no irq at level 0", int'(irq), 0);
    chk("R8 level 0 output", int'(irq_level), 0);
    wr_ctl(0, 5, 1'b0);
    chk("R8 irq at level 5", int'(irq), 1);
    chk("R8 level 5", int'(irq_level), 5);

    // shadow: new values from next period
    @(mon_rise);
    push(20, 6, "R5 running period keeps old");
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd2);
    push(12, 4, "R5 new values next period");
    push(12, 4, "R5 new values next period");
    wait_empty();

    // minimum pulse
    wr(2'd0, 16'd7);
    wr(2'd1, 16'd1);
    @(mon_rise); @(mon_rise);
    push(16, 2, "R3 one tick pulse");
    wait_empty();

    // prescaler codes
    wr_ctl(3, 5, 1'b0);
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    @(mon_rise); @(mon_rise);
    push(64, 16, "R2 code 3 div16");
    push(64, 16, "R2 code 3 div16");
    wait_empty();
    wr_ctl(5, 5, 1'b0);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd2);
    @(mon_rise); @(mon_rise);
    push(192, 128, "R2 code 5 div64");
    wait_empty();
    wr_ctl(7, 5, 1'b0);
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    @(mon_rise); @(mon_rise);
    push(1024, 512, "R2 code 7 div512");
    wait_empty();

    // freeze, div 4, P=4 W=2: period 20, high 8
    wr_ctl(1, 5, 1'b0);
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd2);
    @(mon_rise); @(mon_rise);
    push(27, 15, "R9 freeze while high");
    freeze = 1'b1;
    repeat (7) @(negedge clk);
    freeze = 1'b0;
    push(20, 8, "R9 after release");
    wait_empty();
    @(mon_rise);
    push(25, 8, "R9 freeze while low");
    repeat (10) @(negedge clk);
    freeze = 1'b1;
    repeat (5) @(negedge clk);
    freeze = 1'b0;
    wait_empty();

    // constant outputs
    wr_ctl(0, 5, 1'b0);
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd5);
    wr_ctl(0, 5, 1'b1);
    while (!flag) @(negedge clk);
    ok = 1;
    repeat (20) begin
      if (!pwm) ok = 0;
      @(negedge clk);
    end
    chk("R4 W>P constant high", ok, 1);
    wr(2'd1, 16'd0);
    wr_ctl(0, 5, 1'b1);
    while (!flag) @(negedge clk);
    ok = 1;
    repeat (20) begin
      if (pwm) ok = 0;
      @(negedge clk);
    end
    chk("R4 W=0 constant low", ok, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule